// File: doc/BRIEF.md
# Three-Wire Serial Clock-Chip Master

This block lets on-chip logic read and write single byte-wide registers of an external real-time clock chip over a three-wire link. The link has a chip-select line that frames each transfer, a serial clock, and one shared data line that the block either drives or releases. The serial clock comes from the system clock through a divider. Each half of the serial clock period lasts `HALF_DIV` system clocks. With the default of 50 and a 50 MHz system clock, the link runs at 500 kHz.

The host starts a transfer with a one-cycle `req` pulse, giving the direction, a 6-bit register address and, for writes, a data byte. The block first sends a command byte, least significant bit first. For a write it follows with the data byte. For a read it turns the data line around at once and shifts in the reply. The `busy` output stays high for the whole transfer, and `done` marks its end.

A second strobe, `probe_req`, runs a presence check. The block writes a fixed pattern to scratch register 0, reads that register back, and raises `absent` when the byte returned does not match.

Top module: `rtc3w_master`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `ce`, `sclk` and `sio_out` are 0, `sio_oe` is 1, and `busy`, `done` and `absent` are 0.
- R2: An accepted request raises `busy` on the next edge. For exactly `HALF_DIV` cycles after that, `ce`, `sclk` and `sio_out` stay low. Then `ce` rises. `sclk` is high only while `ce` is high, and `ce` and `sclk` are low whenever `busy` is low.
- R3: The first byte sent is the command byte. Bit 7 is always 1, bits 6:1 carry the register address, and bit 0 is 1 for a read and 0 for a write.
- R4: Every byte is sent bit 0 first, with exactly eight `sclk` rising edges per byte. Each high half of `sclk`, and each low half between two pulses, lasts `HALF_DIV` system clocks. `sio_out` changes only while `sclk` is low.
- R5: A write sends the command byte and then the data byte, 16 pulses in all, and then lowers `ce`. The addressed register then holds the data byte.
- R6: A read sends the 8-bit command, then releases the data line before the next pulse. It then takes in eight bits, bit 0 first. Each bit is sampled at the end of the low half that comes before its pulse. After 16 pulses, `ce` falls and `rdata` holds the byte received.
- R7: `sio_oe` is 0 only during the receive phase of a read. It returns to 1 one cycle after `ce` falls.
- R8: `done` is high for exactly one cycle per host operation, in the first cycle in which `ce` is low again. `busy` falls on the following edge.
- R9: A `req` or `probe_req` that arrives while `busy` is high has no effect. When `req` and `probe_req` arrive together in an idle cycle, only the host request is carried out.
- R10: A presence check runs two transfers: a write of 0x42 to address 0, then a read of address 0. It gives a single `done` pulse, at the end of the read. When `busy` falls, `absent` is 1 if the byte read back is not 0x42 and 0 if it is. It keeps that value until the next check.
- R11: `rdata` changes only when a read completes. Writes and idle time leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | One-cycle host transfer strobe |
| rd_nwr | input | 1 | 1 = read, 0 = write, sampled with `req` |
| addr | input | 6 | Register address, sampled with `req` |
| wdata | input | 8 | Write byte, sampled with `req` |
| probe_req | input | 1 | One-cycle presence-check strobe |
| rdata | output | 8 | Last byte read from the chip |
| busy | output | 1 | Transfer or presence check in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| absent | output | 1 | Result of the last presence check: 1 if the readback did not match |
| ce | output | 1 | Link chip-select, high during a transfer |
| sclk | output | 1 | Link serial clock |
| sio_out | output | 1 | Data value driven onto the link |
| sio_oe | output | 1 | 1 = block drives the data line |
| sio_in | input | 1 | Data value read from the link |

## Verification
The assertions assume that reset is applied before any request. They also assume that `sio_in` matters only while the data line is released, so none of them looks at it during the phases in which the block drives the line. The bench drives every strobe as a single-cycle pulse on the falling clock edge, keeps `addr`, `wdata` and `rd_nwr` steady around it, and sends a new request only after `busy` has dropped, except in the cases that test requests arriving while busy. Its chip model changes `sio_in` only after a falling `sclk` edge while the line is released, and holds it at 0 otherwise.

// File: rtl/rtc3w_pkg.sv
`timescale 1ns/1ps
package rtc3w_pkg;

  // Link geometry fixed by the command format
  localparam int ADDR_W  = 6;
  localparam int BYTE_W  = 8;
  localparam int BIT_CW  = $clog2(BYTE_W);

  typedef enum logic [3:0] {
    SQ_IDLE,   // nothing on the link
    SQ_LOW,    // all lines held low before framing
    SQ_CE,     // chip-select up, clock low
    SQ_BLO,    // transmit bit, clock low
    SQ_BHI,    // transmit bit, clock high
    SQ_RLO,    // receive bit, clock low (sample at end)
    SQ_RHI,    // receive bit, clock high
    SQ_TAIL,   // last half before chip-select drops
    SQ_FIN     // chip-select low, line released -> driven again
  } seq_state_t;

  typedef enum logic [2:0] {
    PR_IDLE,
    PR_WR,     // launch pattern write
    PR_WWAIT,  // wait write end
    PR_RD,     // launch readback
    PR_RWAIT   // wait readback end
  } probe_state_t;

  // Command: marker in the top bit, address above the direction bit
  function automatic logic [BYTE_W-1:0] make_cmd(input logic [ADDR_W-1:0] a,
                                                 input logic rd);
    return {1'b1, a, rd};
  endfunction

endpackage

// File: rtl/rtc3w_tick.sv
`timescale 1ns/1ps
module rtc3w_tick #(
  parameter int HALF_DIV = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)      cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/rtc3w_seq.sv
`timescale 1ns/1ps
module rtc3w_seq
  import rtc3w_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              start,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              sio_in,
  output logic              run,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rdata,
  output logic              ce,
  output logic              sclk,
  output logic              sio_out,
  output logic              sio_oe
);
  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);

  seq_state_t        st;
  logic [BIT_CW-1:0] bcnt;
  logic              in_data;
  logic              is_rd;
  logic [BYTE_W-1:0] txsh;
  logic [BYTE_W-1:0] wbuf;
  logic [BYTE_W-1:0] rxsh;

  assign run = (st != SQ_IDLE) && (st != SQ_FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SQ_IDLE;
      bcnt    <= '0;
      in_data <= 1'b0;
      is_rd   <= 1'b0;
      txsh    <= '0;
      wbuf    <= '0;
      rxsh    <= '0;
      rdata   <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      ce      <= 1'b0;
      sclk    <= 1'b0;
      sio_out <= 1'b0;
      sio_oe  <= 1'b1;
    end else begin
      done <= 1'b0;
      case (st)
        SQ_IDLE: if (start) begin
          st      <= SQ_LOW;
          busy    <= 1'b1;
          ce      <= 1'b0;
          sclk    <= 1'b0;
          sio_out <= 1'b0;
          sio_oe  <= 1'b1;
          txsh    <= make_cmd(addr, rd);
          wbuf    <= wdata;
          is_rd   <= rd;
          bcnt    <= '0;
          in_data <= 1'b0;
        end
        SQ_LOW: if (tick) begin
          ce <= 1'b1;
          st <= SQ_CE;
        end
        SQ_CE: if (tick) begin
          sio_out <= txsh[0];
          st      <= SQ_BLO;
        end
        SQ_BLO: if (tick) begin
          sclk <= 1'b1;
          st   <= SQ_BHI;
        end
        SQ_BHI: if (tick) begin
          sclk <= 1'b0;
          bcnt <= bcnt + 1'b1;
          if (bcnt == LAST_BIT) begin
            if (in_data) begin
              sio_out <= 1'b0;
              st      <= SQ_TAIL;
            end else if (is_rd) begin
              sio_out <= 1'b0;
              sio_oe  <= 1'b0;
              st      <= SQ_RLO;
            end else begin
              in_data <= 1'b1;
              txsh    <= wbuf;
              sio_out <= wbuf[0];
              st      <= SQ_BLO;
            end
          end else begin
            txsh    <= txsh >> 1;
            sio_out <= txsh[1];
            st      <= SQ_BLO;
          end
        end
        SQ_RLO: if (tick) begin
          rxsh <= {sio_in, rxsh[BYTE_W-1:1]};
          sclk <= 1'b1;
          st   <= SQ_RHI;
        end
        SQ_RHI: if (tick) begin
          sclk <= 1'b0;
          bcnt <= bcnt + 1'b1;
          if (bcnt == LAST_BIT) st <= SQ_TAIL;
          else                  st <= SQ_RLO;
        end
        SQ_TAIL: if (tick) begin
          ce   <= 1'b0;
          done <= 1'b1;
          if (is_rd) rdata <= rxsh;
          st   <= SQ_FIN;
        end
        SQ_FIN: begin
          sio_oe <= 1'b1;
          busy   <= 1'b0;
          st     <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rtc3w_probe.sv
`timescale 1ns/1ps
module rtc3w_probe
  import rtc3w_pkg::*;
#(
  parameter logic [BYTE_W-1:0] PATTERN  = 8'h42,
  parameter logic [ADDR_W-1:0] TEST_REG = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              seq_busy,
  input  logic              seq_done,
  input  logic [BYTE_W-1:0] seq_rdata,
  output logic              active,
  output logic              last,
  output logic              start,
  output logic              rd,
  output logic [ADDR_W-1:0] addr,
  output logic [BYTE_W-1:0] wdata,
  output logic              absent
);
  probe_state_t ps;

  assign active = (ps != PR_IDLE);
  assign last   = (ps == PR_RWAIT);
  assign start  = ((ps == PR_WR) || (ps == PR_RD)) && !seq_busy;
  assign rd     = (ps == PR_RD);
  assign addr   = TEST_REG;
  assign wdata  = PATTERN;

  always_ff @(posedge clk) begin
    if (rst) begin
      ps     <= PR_IDLE;
      absent <= 1'b0;
    end else begin
      case (ps)
        PR_IDLE:  if (go)       ps <= PR_WR;
        PR_WR:    if (start)    ps <= PR_WWAIT;
        PR_WWAIT: if (seq_done) ps <= PR_RD;
        PR_RD:    if (start)    ps <= PR_RWAIT;
        PR_RWAIT: if (seq_done) begin
          absent <= (seq_rdata != PATTERN);
          ps     <= PR_IDLE;
        end
        default: ps <= PR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rtc3w_master.sv
`timescale 1ns/1ps
module rtc3w_master
  import rtc3w_pkg::*;
#(
  parameter int                HALF_DIV = 50,
  parameter logic [BYTE_W-1:0] PATTERN  = 8'h42
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              rd_nwr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              probe_req,
  output logic [BYTE_W-1:0] rdata,
  output logic              busy,
  output logic              done,
  output logic              absent,
  output logic              ce,
  output logic              sclk,
  output logic              sio_out,
  output logic              sio_oe,
  input  logic              sio_in
);
  logic              run, tick;
  logic              seq_busy, seq_done;
  logic              seq_start, seq_rd;
  logic [ADDR_W-1:0] seq_addr;
  logic [BYTE_W-1:0] seq_wdata;
  logic              p_active, p_last, p_start, p_rd;
  logic [ADDR_W-1:0] p_addr;
  logic [BYTE_W-1:0] p_wdata;
  logic              host_go, probe_go;

  assign busy     = seq_busy | p_active;
  assign host_go  = req & ~busy;
  assign probe_go = probe_req & ~req & ~busy;

  assign seq_start = p_active ? p_start : host_go;
  assign seq_rd    = p_active ? p_rd    : rd_nwr;
  assign seq_addr  = p_active ? p_addr  : addr;
  assign seq_wdata = p_active ? p_wdata : wdata;
  assign done      = seq_done & (~p_active | p_last);

  rtc3w_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst(rst), .run(run), .tick(tick)
  );

  rtc3w_seq u_seq (
    .clk(clk), .rst(rst), .tick(tick),
    .start(seq_start), .rd(seq_rd), .addr(seq_addr), .wdata(seq_wdata),
    .sio_in(sio_in), .run(run), .busy(seq_busy), .done(seq_done),
    .rdata(rdata), .ce(ce), .sclk(sclk), .sio_out(sio_out), .sio_oe(sio_oe)
  );

  rtc3w_probe #(.PATTERN(PATTERN), .TEST_REG('0)) u_probe (
    .clk(clk), .rst(rst), .go(probe_go),
    .seq_busy(seq_busy), .seq_done(seq_done), .seq_rdata(rdata),
    .active(p_active), .last(p_last), .start(p_start), .rd(p_rd),
    .addr(p_addr), .wdata(p_wdata), .absent(absent)
  );
endmodule

// File: rtl/rtc3w_checker.sv
`timescale 1ns/1ps
module rtc3w_checker (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic ce,
  input logic sclk,
  input logic sio_out,
  input logic sio_oe
);
  assert_idle_lines_low_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!ce && !sclk && sio_oe));

  assert_sclk_inside_ce_R2: assert property (@(posedge clk) disable iff (rst)
    sclk |-> ce);

  assert_ce_rise_clean_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ce) |-> (!sclk && !sio_out && $past(!sclk && !sio_out)));

  assert_data_steady_high_R4: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(sio_out));

  assert_oe_release_R7: assert property (@(posedge clk) disable iff (rst)
    !sio_oe |-> (ce || $past(ce)));

  assert_oe_drop_clock_low_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(sio_oe) |-> (ce && !sclk));

  assert_done_on_ce_fall_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!ce && $past(ce)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_busy_drop_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);

  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);
endmodule

bind rtc3w_master rtc3w_checker u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .ce(ce),
  .sclk(sclk), .sio_out(sio_out), .sio_oe(sio_oe)
);

// File: tb/tb_rtc3w_master.sv
`timescale 1ns/1ps
module tb_rtc3w_master;
  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req = 1'b0;
  logic       rd_nwr = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       probe_req = 1'b0;
  logic [7:0] rdata;
  logic       busy, done, absent, ce, sclk, sio_out, sio_oe;
  logic       sio_in;

  int n_chk = 0;
  int n_bad = 0;
  bit absent_mode = 1'b0;

  always #10 clk = ~clk;

  rtc3w_master #(.HALF_DIV(HALF)) dut (
    .clk(clk), .rst(rst), .req(req), .rd_nwr(rd_nwr), .addr(addr),
    .wdata(wdata), .probe_req(probe_req), .rdata(rdata), .busy(busy),
    .done(done), .absent(absent), .ce(ce), .sclk(sclk), .sio_out(sio_out),
    .sio_oe(sio_oe), .sio_in(sio_in)
  );

  // ---------------- clock-chip model ----------------
  logic [7:0] mem [64];
  logic [7:0] cmd, wbyte, last_cmd;
  int nbit = 0, ntxn = 0, m_oe_bad = 0;
  logic mp_ce = 1'b0, mp_sclk = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) mem[i] = 8'h00;
      nbit = 0; sio_in = 1'b0; cmd = '0; wbyte = '0; last_cmd = '0;
      mp_ce = 1'b0; mp_sclk = 1'b0;
    end else begin
      if (ce && !mp_ce) begin nbit = 0; ntxn++; end
      if (ce && sclk && !mp_sclk) begin
        if (nbit < 8) begin
          cmd[nbit] = sio_out;
          if (!sio_oe) m_oe_bad++;
          if (nbit == 7) last_cmd = cmd;
        end else if (cmd[0]) begin
          if (sio_oe) m_oe_bad++;
        end else begin
          wbyte[nbit-8] = sio_out;
          if (!sio_oe) m_oe_bad++;
        end
        nbit++;
        if (nbit == 16 && !cmd[0] && !absent_mode) mem[cmd[6:1]] = wbyte;
      end
      if (ce && !sclk && mp_sclk && cmd[0] && nbit >= 8 && nbit < 16)
        sio_in = absent_mode ? 1'b1 : mem[cmd[6:1]][nbit-8];
      else if (!ce)
        sio_in = 1'b0;
      mp_ce = ce; mp_sclk = sclk;
    end
  end

  // ---------------- link monitor ----------------
  int rises = 0, tim_bad = 0, done_cnt = 0, done_bad = 0, oe_bad = 0;
  int run_len = 0, lat_cnt = 0, lat_last = 0;
  bit fell_seen = 0, lat_done = 0;
  logic m_sclk = 0, m_ce = 0, m_busy = 0, m_done = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (sclk != m_sclk) begin
        if (m_sclk) begin
          if (run_len != HALF) tim_bad++;
          fell_seen = 1;
        end else begin
          rises++;
          if (fell_seen && run_len != HALF) tim_bad++;
        end
        run_len = 1;
      end else run_len++;
      if (busy && !m_busy) begin lat_cnt = 0; lat_done = 0; end
      if (busy && !ce && !lat_done) lat_cnt++;
      if (ce && !m_ce) begin
        fell_seen = 0;
        if (!lat_done) begin lat_last = lat_cnt; lat_done = 1; end
      end
      if (done) begin
        done_cnt++;
        if (ce || !m_ce) done_bad++;
      end
      if (m_done && !sio_oe) oe_bad++;
      if (!ce && !m_ce && !sio_oe) oe_bad++;
    end
    m_sclk = sclk; m_ce = ce; m_busy = busy; m_done = done;
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin step(); n++; end
    if (busy) chk("R8 busy never fell", 1, 0);
    step(); step();
  endtask

  task automatic pulse_host(input logic r, input logic [5:0] a, input logic [7:0] d);
    step();
    req = 1'b1; rd_nwr = r; addr = a; wdata = d;
    step();
    req = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R1 ce", ce, 0);
    chk("R1 sclk", sclk, 0);
    chk("R1 sio_out", sio_out, 0);
    chk("R1 sio_oe", sio_oe, 1);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 absent", absent, 0);
  endtask

  task automatic t_write(input logic [5:0] a, input logic [7:0] d);
    int r0, t0, d0, db0, o0, mo0, n0;
    step();
    r0 = rises; t0 = tim_bad; d0 = done_cnt; db0 = done_bad;
    o0 = oe_bad; mo0 = m_oe_bad; n0 = ntxn;
    pulse_host(1'b0, a, d);
    wait_idle();
    chk("R3 write command byte", last_cmd, {1'b1, a, 1'b0});
    chk("R5 register written", mem[a], d);
    chk("R4 pulses per write", rises - r0, 16);
    chk("R4 half-period timing", tim_bad - t0, 0);
    chk("R2 low lead-in cycles", lat_last, HALF);
    chk("R5 one framed transfer", ntxn - n0, 1);
    chk("R8 done pulses", done_cnt - d0, 1);
    chk("R8 done on ce fall", done_bad - db0, 0);
    chk("R7 oe stays driven on write", (oe_bad - o0) + (m_oe_bad - mo0), 0);
  endtask

  task automatic t_read(input logic [5:0] a, input logic [7:0] exp);
    int r0, t0, d0, o0, mo0;
    step();
    r0 = rises; t0 = tim_bad; d0 = done_cnt; o0 = oe_bad; mo0 = m_oe_bad;
    pulse_host(1'b1, a, 8'h00);
    wait_idle();
    chk("R3 read command byte", last_cmd, {1'b1, a, 1'b1});
    chk("R6 read data", rdata, exp);
    chk("R6 pulses per read", rises - r0, 16);
    chk("R4 half-period timing on read", tim_bad - t0, 0);
    chk("R6 line released while receiving", m_oe_bad - mo0, 0);
    chk("R7 oe restored after ce fall", oe_bad - o0, 0);
    chk("R7 oe driven at rest", sio_oe, 1);
    chk("R8 done pulses on read", done_cnt - d0, 1);
  endtask

  task automatic t_hold();
    logic [7:0] keep;
    keep = rdata;
    t_write(6'h2A, 8'h18);
    chk("R11 rdata after write", rdata, keep);
    repeat (20) step();
    chk("R11 rdata after idle", rdata, keep);
  endtask

  task automatic t_busy_ignore();
    int n0;
    t_write(6'h06, 8'h5C);
    step();
    n0 = ntxn;
    pulse_host(1'b0, 6'h05, 8'h3C);
    chk("R8 busy after accept", busy, 1);
    repeat (10) step();
    req = 1'b1; rd_nwr = 1'b0; addr = 6'h06; wdata = 8'h77;
    probe_req = 1'b1;
    step();
    req = 1'b0; probe_req = 1'b0;
    wait_idle();
    chk("R9 extra request ignored", ntxn - n0, 1);
    chk("R9 ignored target untouched", mem[6'h06], 8'h5C);
    chk("R9 accepted write landed", mem[6'h05], 8'h3C);
  endtask

  task automatic t_simul();
    int n0;
    t_write(6'h00, 8'h11);
    t_write(6'h09, 8'h5A);
    step();
    n0 = ntxn;
    req = 1'b1; rd_nwr = 1'b1; addr = 6'h09; wdata = 8'h00; probe_req = 1'b1;
    step();
    req = 1'b0; probe_req = 1'b0;
    wait_idle();
    chk("R9 host wins over probe", ntxn - n0, 1);
    chk("R9 host read result", rdata, 8'h5A);
    chk("R9 probe did not write", mem[0], 8'h11);
  endtask

  task automatic t_probe(input bit mode, input logic exp_abs);
    int n0, d0;
    absent_mode = mode;
    step();
    n0 = ntxn; d0 = done_cnt;
    probe_req = 1'b1;
    step();
    probe_req = 1'b0;
    wait_idle();
    chk("R10 two transfers", ntxn - n0, 2);
    chk("R10 single done", done_cnt - d0, 1);
    chk("R10 absent flag", absent, exp_abs);
    if (!mode) chk("R10 pattern stored at reg 0", mem[0], 8'h42);
    repeat (10) step();
    chk("R10 flag held", absent, exp_abs);
    absent_mode = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    step();
    t_reset();
    t_write(6'h05, 8'hA5);
    t_read(6'h05, 8'hA5);
    t_write(6'h3F, 8'hFF);
    t_read(6'h3F, 8'hFF);
    t_write(6'h00, 8'h00);
    t_read(6'h00, 8'h00);
    t_write(6'h2A, 8'h81);
    t_read(6'h2A, 8'h81);
    t_hold();
    t_busy_ignore();
    t_simul();
    t_probe(1'b0, 1'b0);
    t_probe(1'b1, 1'b1);
    t_probe(1'b0, 1'b0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule